// File: doc/BRIEF.md
# Dual-Framed DAC Serial Register Bank

This block is the digital control plane for a bank of DAC channels split into equal groups. All groups share one serial clock and one serial data line. Each group has its own active-low frame select. A frame is a fixed-length word shifted in MSB first on falling serial-clock edges. When the last bit arrives, the word is decoded against the group that owned the frame. It can load a channel's input register, move an input register to the channel's DAC register, set power-down modes, program the clear code, pick which channels follow the load strobe, or switch the group's reference on.

The load and clear strobes are asynchronous pins. A held-low load strobe makes every write reach the DAC register at once. A falling load edge copies input registers to DAC registers for every channel enabled in the load mask. A falling clear edge forces every input and DAC register to the programmed clear code. The load strobe is ignored while clear is held low. All serial and strobe pins are brought into the system clock domain through synchronizers, so the serial clock must be slow relative to `clk`.

The analog strings and amplifiers sit outside the block. It exports each channel's 12-bit DAC register, its 2-bit power-down mode and one reference enable per group.

Top module: `dacbank_top`

## Requirements
- R1: After reset every DAC register reads 0, every power-down mode reads 00 and both reference enables read 0.
- R2: A frame is 32 bits, MSB first, captured on falling edges of `ser_clk` while the group's `frame_n` bit is low. Bits 31:28 hold the command, bits 27:24 the address, bits 23:12 the data and bits 11:0 are padding. `frame_n[0]` reaches channels 0 to 7 and `frame_n[1]` reaches channels 8 to 15. Address bits 2:0 pick the channel within the group and address bit 3 is ignored.
- R3: If the frame select rises before the 32nd falling edge, the partial word is dropped and no register changes.
- R4: Command 0 writes the input register. While `load_n` is high the DAC register keeps its value until a falling `load_n` edge copies the input register across.
- R5: While `load_n` is held low, command 0 also updates the addressed DAC register.
- R6: Command 1 copies the addressed input register to its DAC register. Command 2 writes the data to both registers.
- R7: Command 6 sets the load mask of the group from data bits 7:0, one bit per channel. Only channels with a set bit are updated by a falling `load_n` edge. The mask is all ones after reset.
- R8: A falling `clear_n` edge loads every input and DAC register with the clear value. Command 5 selects the clear value from data bits 1:0: 0 gives 0x000, 1 gives 0x800, 2 gives 0xFFF and 3 gives 0x000. The value after reset is 0x000.
- R9: Falling `load_n` edges that occur while `clear_n` is low have no effect.
- R10: Command 4 writes the mode in data bits 9:8 to every channel of the group whose bit is set in data bits 7:0. The modes are 00 normal, 01 1 kΩ to ground, 10 100 kΩ to ground and 11 three-state.
- R11: Command 7 sets the group's reference enable to data bit 0.
- R12: Command values 3 and 8 to 15 change nothing.
- R13: Falling edges after the 32nd one in the same frame are ignored until the frame select rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Shared serial clock; data captured on its falling edge |
| ser_dat | input | 1 | Shared serial data, MSB first |
| frame_n | input | 2 | Active-low frame select, one bit per channel group |
| load_n | input | 1 | Load strobe: held low for automatic update, falling edge for a masked update |
| clear_n | input | 1 | Clear strobe, acting on its falling edge |
| dac_code | output | 192 | DAC register of channel n at bits n*12+11:n*12 |
| pd_mode | output | 32 | Power-down mode of channel n at bits n*2+1:n*2 |
| ref_on | output | 2 | Reference enable of each group |

## Verification
The hardest case to reach is a load edge that lands while clear is held low. At that point the input registers hold data that differ from the DAC registers, so a load that wrongly gets through shows up as a changed output. The stimulus first pulls `clear_n` low, writes a new input value through the serial port while clear stays low, and then pulses `load_n`. Only after `clear_n` is released does a second load pulse make the new value appear. Frame aborts at 20 and 31 bits, and a second full word clocked in after the 32nd edge of one frame, cover the edge-count boundaries.

// File: rtl/dacbank_pkg.sv
package dacbank_pkg;

   typedef enum logic [3:0] {
      CMD_WR_IN   = 4'h0,
      CMD_UPD     = 4'h1,
      CMD_WR_UPD  = 4'h2,
      CMD_PWR     = 4'h4,
      CMD_CLRSET  = 4'h5,
      CMD_LDMASK  = 4'h6,
      CMD_REF     = 4'h7
   } cmd_e;

   localparam int CMD_W  = 4;
   localparam int ADDR_W = 4;
   localparam int PD_W   = 2;

   typedef enum logic [1:0] {
      CLR_ZERO  = 2'd0,
      CLR_MID   = 2'd1,
      CLR_FULL  = 2'd2,
      CLR_ZERO2 = 2'd3
   } clr_e;

endpackage

// File: rtl/dacbank_sync.sv
module dacbank_sync #(
   parameter int W      = 4,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q,
   output logic [W-1:0] rise,
   output logic [W-1:0] fall
);

   logic [W-1:0] stg [STAGES];
   logic [W-1:0] prev_q;

   generate
      genvar s;
      for (s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[s] <= '1;
               else        stg[s] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[s] <= '1;
               else        stg[s] <= stg[s-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '1;
      else        prev_q <= stg[STAGES-1];
   end

   assign q    = stg[STAGES-1];
   assign rise = stg[STAGES-1] & ~prev_q;
   assign fall = ~stg[STAGES-1] & prev_q;

endmodule

// File: rtl/dacbank_frame.sv
module dacbank_frame #(
   parameter int FB = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sel_n,
   input  logic          sclk_fall,
   input  logic          sdat,
   output logic [FB-1:0] word_o,
   output logic          vld_o
);

   localparam int CW = $clog2(FB + 1);

   logic [CW-1:0] cnt_q;
   logic [FB-1:0] sh_q;
   logic [FB-1:0] sh_nxt;

   assign sh_nxt = {sh_q[FB-2:0], sdat};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         sh_q   <= '0;
         word_o <= '0;
         vld_o  <= 1'b0;
      end else begin
         vld_o <= 1'b0;
         if (sel_n) begin
            cnt_q <= '0;
         end else if (sclk_fall && (cnt_q < CW'(FB))) begin
            sh_q  <= sh_nxt;
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CW'(FB - 1)) begin
               vld_o  <= 1'b1;
               word_o <= sh_nxt;
            end
         end
      end
   end

endmodule

// File: rtl/dacbank_regs.sv
module dacbank_regs
   import dacbank_pkg::*;
#(
   parameter int NGRP = 2,
   parameter int CPG  = 8,
   parameter int DW   = 12,
   parameter int FB   = 32
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [NGRP-1:0]         frm_vld,
   input  logic [FB-1:0]           frm_word [NGRP],
   input  logic                    load_lvl,
   input  logic                    load_fall,
   input  logic                    clr_lvl,
   input  logic                    clr_fall,
   output logic [NGRP*CPG*DW-1:0]  dac_flat,
   output logic [NGRP*CPG*PD_W-1:0] pd_flat,
   output logic [NGRP-1:0]         ref_on,
   output logic [DW-1:0]           clr_value
);

   localparam int NCH     = NGRP * CPG;
   localparam int AW      = $clog2(CPG);
   localparam int IW      = $clog2(NCH);
   localparam int CMD_LSB = FB - CMD_W;
   localparam int ADR_LSB = CMD_LSB - ADDR_W;
   localparam int DAT_LSB = ADR_LSB - DW;

   logic [DW-1:0]   in_q   [NCH];
   logic [DW-1:0]   dac_q  [NCH];
   logic [PD_W-1:0] pd_q   [NCH];
   logic [NCH-1:0]  mask_q;
   logic [1:0]      clr_code_q;
   logic [NGRP-1:0] ref_q;

   cmd_e            cmd  [NGRP];
   logic [IW-1:0]   idx  [NGRP];
   logic [DW-1:0]   dat  [NGRP];

   generate
      genvar g;
      for (g = 0; g < NGRP; g++) begin : g_dec
         logic [AW-1:0] sel;
         assign cmd[g] = cmd_e'(frm_word[g][CMD_LSB +: CMD_W]);
         assign sel    = frm_word[g][ADR_LSB +: AW];
         assign dat[g] = frm_word[g][DAT_LSB +: DW];
         assign idx[g] = IW'(g * CPG) + IW'(sel);
      end
   endgenerate

   always_comb begin
      unique case (clr_e'(clr_code_q))
         CLR_MID:  clr_value = {1'b1, {(DW-1){1'b0}}};
         CLR_FULL: clr_value = '1;
         default:  clr_value = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int c = 0; c < NCH; c++) begin
            in_q[c]  <= '0;
            dac_q[c] <= '0;
            pd_q[c]  <= '0;
         end
         mask_q     <= '1;
         clr_code_q <= '0;
         ref_q      <= '0;
      end else begin
         // masked transfer on a load edge, blocked while clear is low
         for (int c = 0; c < NCH; c++) begin
            if (load_fall && clr_lvl && mask_q[c]) dac_q[c] <= in_q[c];
         end
         // completed frames
         for (int gi = 0; gi < NGRP; gi++) begin
            if (frm_vld[gi]) begin
               case (cmd[gi])
                  CMD_WR_IN: begin
                     in_q[idx[gi]] <= dat[gi];
                     if (!load_lvl) dac_q[idx[gi]] <= dat[gi];
                  end
                  CMD_UPD: dac_q[idx[gi]] <= in_q[idx[gi]];
                  CMD_WR_UPD: begin
                     in_q[idx[gi]]  <= dat[gi];
                     dac_q[idx[gi]] <= dat[gi];
                  end
                  CMD_PWR: begin
                     for (int c = 0; c < CPG; c++) begin
                        if (dat[gi][c]) pd_q[gi*CPG + c] <= dat[gi][CPG +: PD_W];
                     end
                  end
                  CMD_CLRSET: clr_code_q <= dat[gi][1:0];
                  CMD_LDMASK: mask_q[gi*CPG +: CPG] <= dat[gi][CPG-1:0];
                  CMD_REF:    ref_q[gi] <= dat[gi][0];
                  default: ;
               endcase
            end
         end
         // clear edge overrides everything else in the same cycle
         if (clr_fall) begin
            for (int c = 0; c < NCH; c++) begin
               in_q[c]  <= clr_value;
               dac_q[c] <= clr_value;
            end
         end
      end
   end

   generate
      genvar ch;
      for (ch = 0; ch < NCH; ch++) begin : g_flat
         assign dac_flat[ch*DW +: DW]   = dac_q[ch];
         assign pd_flat[ch*PD_W +: PD_W] = pd_q[ch];
      end
   endgenerate

   assign ref_on = ref_q;

endmodule

// File: rtl/dacbank_top.sv
module dacbank_top
   import dacbank_pkg::*;
#(
   parameter int NGRP        = 2,
   parameter int CPG         = 8,
   parameter int DW          = 12,
   parameter int FRAME_BITS  = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         ser_clk,
   input  logic                         ser_dat,
   input  logic [NGRP-1:0]              frame_n,
   input  logic                         load_n,
   input  logic                         clear_n,
   output logic [NGRP*CPG*DW-1:0]       dac_code,
   output logic [NGRP*CPG*PD_W-1:0]     pd_mode,
   output logic [NGRP-1:0]              ref_on
);

   localparam int NCH = NGRP * CPG;
   localparam int SW  = NGRP + 4;

   generate
      if (FRAME_BITS < CMD_W + ADDR_W + DW) begin : g_bad_frame
         $error("dacbank_top: FRAME_BITS too small for command, address and data");
      end
      if ((CPG < 2) || (CPG > (1 << ADDR_W)) || ((CPG & (CPG - 1)) != 0)) begin : g_bad_cpg
         $error("dacbank_top: CPG must be a power of two between 2 and 16");
      end
      if (DW < CPG + PD_W) begin : g_bad_dw
         $error("dacbank_top: DW too narrow for channel mask and power-down mode");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("dacbank_top: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [SW-1:0]   raw, lvl, rise, fall;
   logic [NGRP-1:0] frm_lvl;
   logic            sclk_fall, sdat_lvl;
   logic            ld_lvl, ld_fall, cl_lvl, cl_fall;
   logic [NGRP-1:0] frm_vld;
   logic [FRAME_BITS-1:0] frm_word [NGRP];
   logic [DW-1:0]   clr_value;

   assign raw = {clear_n, load_n, ser_dat, ser_clk, frame_n};

   dacbank_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (raw),
      .q    (lvl),
      .rise (rise),
      .fall (fall)
   );

   assign frm_lvl   = lvl[NGRP-1:0];
   assign sclk_fall = fall[NGRP];
   assign sdat_lvl  = lvl[NGRP+1];
   assign ld_lvl    = lvl[NGRP+2];
   assign ld_fall   = fall[NGRP+2];
   assign cl_lvl    = lvl[NGRP+3];
   assign cl_fall   = fall[NGRP+3];

   generate
      genvar g;
      for (g = 0; g < NGRP; g++) begin : g_rx
         dacbank_frame #(.FB(FRAME_BITS)) u_rx (
            .clk      (clk),
            .rst_n    (rst_n),
            .sel_n    (frm_lvl[g]),
            .sclk_fall(sclk_fall),
            .sdat     (sdat_lvl),
            .word_o   (frm_word[g]),
            .vld_o    (frm_vld[g])
         );
      end
   endgenerate

   dacbank_regs #(.NGRP(NGRP), .CPG(CPG), .DW(DW), .FB(FRAME_BITS)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .frm_vld  (frm_vld),
      .frm_word (frm_word),
      .load_lvl (ld_lvl),
      .load_fall(ld_fall),
      .clr_lvl  (cl_lvl),
      .clr_fall (cl_fall),
      .dac_flat (dac_code),
      .pd_flat  (pd_mode),
      .ref_on   (ref_on),
      .clr_value(clr_value)
   );

endmodule

// File: rtl/dacbank_chk.sv
module dacbank_chk #(
   parameter int NGRP = 2,
   parameter int NCH  = 16,
   parameter int DW   = 12
) (
   input logic                clk,
   input logic                rst_n,
   input logic [NGRP-1:0]     frm_vld,
   input logic                ld_fall,
   input logic                cl_fall,
   input logic                cl_lvl,
   input logic [NCH*DW-1:0]   dac_code,
   input logic [NCH*2-1:0]    pd_mode,
   input logic [NGRP-1:0]     ref_on,
   input logic [DW-1:0]       clr_value
);

   logic [NCH*DW-1:0] clr_rep;
   assign clr_rep = {NCH{clr_value}};

   // R1
   rst_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) == 1'b0) |-> (dac_code == '0 && pd_mode == '0 && ref_on == '0));

   // R8
   clr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cl_fall |=> (dac_code == $past(clr_rep)));

   // R9
   ld_in_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_fall && !cl_lvl && !cl_fall && !(|frm_vld)) |=> $stable(dac_code));

   // R3
   dac_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_fall && !cl_fall && !(|frm_vld)) |=> $stable(dac_code));

   // R10
   pd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(|frm_vld) |=> $stable(pd_mode));

   // R11
   ref_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(|frm_vld) |=> $stable(ref_on));

   generate
      genvar g;
      for (g = 0; g < NGRP; g++) begin : g_pulse
         // R13
         vld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
            frm_vld[g] |=> !frm_vld[g]);
      end
   endgenerate

endmodule

bind dacbank_top dacbank_chk #(.NGRP(NGRP), .NCH(NCH), .DW(DW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .frm_vld  (frm_vld),
   .ld_fall  (ld_fall),
   .cl_fall  (cl_fall),
   .cl_lvl   (cl_lvl),
   .dac_code (dac_code),
   .pd_mode  (pd_mode),
   .ref_on   (ref_on),
   .clr_value(clr_value)
);

// File: tb/sim_dacbank_top.sv
module sim_dacbank_top;

   localparam int CLK_PERIOD = 10;
   localparam int HALF       = 4;
   localparam int WDOG       = 200000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ser_clk = 1'b1;
   logic          ser_dat = 1'b0;
   logic [1:0]    frame_n = 2'b11;
   logic          load_n = 1'b1;
   logic          clear_n = 1'b1;
   logic [191:0]  dac_code;
   logic [31:0]   pd_mode;
   logic [1:0]    ref_on;

   int nchk = 0;
   int nerr = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dacbank_top u0 (
      .clk     (clk),
      .rst_n   (rst_n),
      .ser_clk (ser_clk),
      .ser_dat (ser_dat),
      .frame_n (frame_n),
      .load_n  (load_n),
      .clear_n (clear_n),
      .dac_code(dac_code),
      .pd_mode (pd_mode),
      .ref_on  (ref_on)
   );

   // {group, cmd, addr, data, check channel, expected, requirement}
   localparam logic [40:0] VEC [8] = '{
      {1'b0, 4'h0, 4'h0, 12'h123, 4'd0,  12'h123, 4'd5},  // R5
      {1'b0, 4'h2, 4'h7, 12'hABC, 4'd7,  12'hABC, 4'd6},  // R6
      {1'b1, 4'h0, 4'h0, 12'h456, 4'd8,  12'h456, 4'd2},  // R2
      {1'b1, 4'h2, 4'hF, 12'hFFF, 4'd15, 12'hFFF, 4'd2},  // R2 address bit 3 ignored
      {1'b0, 4'h0, 4'h3, 12'h001, 4'd3,  12'h001, 4'd5},  // R5
      {1'b1, 4'h0, 4'h5, 12'h800, 4'd13, 12'h800, 4'd5},  // R5
      {1'b0, 4'hF, 4'h0, 12'h777, 4'd0,  12'h123, 4'd12}, // R12
      {1'b1, 4'h9, 4'h0, 12'h555, 4'd8,  12'h456, 4'd12}  // R12
   };

   function automatic logic [31:0] mk(input logic [3:0] cmd, input logic [3:0] adr,
                                      input logic [11:0] dat);
      return {cmd, adr, dat, 12'h000};
   endfunction

   function automatic logic [11:0] chv(input int c);
      return dac_code[c*12 +: 12];
   endfunction

   task automatic wclk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic send_frame(input int g, input logic [31:0] w, input int nbits,
                             input logic [31:0] xw, input int extra);
      frame_n[g] = 1'b0;
      wclk(HALF);
      for (int i = 0; i < nbits + extra; i++) begin
         ser_dat = (i < nbits) ? w[31-i] : xw[31-(i-nbits)];
         wclk(HALF);
         ser_clk = 1'b0;
         wclk(HALF);
         ser_clk = 1'b1;
      end
      wclk(HALF);
      frame_n[g] = 1'b1;
      wclk(10);
   endtask

   task automatic pulse_load();
      load_n = 1'b0; wclk(8);
      load_n = 1'b1; wclk(8);
   endtask

   task automatic pulse_clear();
      clear_n = 1'b0; wclk(8);
      clear_n = 1'b1; wclk(8);
   endtask

   task automatic report();
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
   endtask

   initial begin
      repeat (WDOG) @(posedge clk);
      if (!done) begin
         nerr++;
         $display("FAIL watchdog expired actual=running expected=finished");
         report();
         $finish;
      end
   end

   initial begin
      load_n = 1'b0;
      wclk(5);
      rst_n = 1'b1;
      wclk(6);
      // R1 reset state
      chk("R1 dac", dac_code[31:0], 32'h0);
      chk("R1 dac high", {20'h0, chv(15)}, 32'h0);
      chk("R1 pd", pd_mode, 32'h0);
      chk("R1 ref", {30'h0, ref_on}, 32'h0);

      // table walk with load held low
      for (int i = 0; i < 8; i++) begin
         logic [40:0] e;
         e = VEC[i];
         send_frame(int'(e[40]), mk(e[39:36], e[35:32], e[31:20]), 32, 32'h0, 0);
         chk($sformatf("R%0d row %0d", e[3:0], i), {20'h0, chv(int'(e[19:16]))},
             {20'h0, e[15:4]});
      end

      load_n = 1'b1;
      wclk(8);
      // R4 input write held until load edge
      send_frame(0, mk(4'h0, 4'h1, 12'h321), 32, 32'h0, 0);
      chk("R4 held", {20'h0, chv(1)}, 32'h0);
      pulse_load();
      chk("R4 loaded", {20'h0, chv(1)}, 32'h321);
      chk("R4 other", {20'h0, chv(7)}, 32'hABC);

      // R6 update command
      send_frame(0, mk(4'h0, 4'h2, 12'h2AA), 32, 32'h0, 0);
      chk("R6 before", {20'h0, chv(2)}, 32'h0);
      send_frame(0, mk(4'h1, 4'h2, 12'h000), 32, 32'h0, 0);
      chk("R6 update", {20'h0, chv(2)}, 32'h2AA);

      // R3 aborted frames
      send_frame(0, mk(4'h2, 4'h4, 12'h999), 20, 32'h0, 0);
      chk("R3 abort 20", {20'h0, chv(4)}, 32'h0);
      send_frame(0, mk(4'h2, 4'h4, 12'h999), 31, 32'h0, 0);
      chk("R3 abort 31", {20'h0, chv(4)}, 32'h0);
      send_frame(0, mk(4'h2, 4'h4, 12'h444), 32, 32'h0, 0);
      chk("R3 recover", {20'h0, chv(4)}, 32'h444);

      // R13 edges after the 32nd ignored
      send_frame(1, mk(4'h2, 4'h1, 12'h0AB), 32, mk(4'h2, 4'h1, 12'h0CD), 32);
      chk("R13 extra", {20'h0, chv(9)}, 32'h0AB);

      // R7 load mask
      send_frame(0, mk(4'h6, 4'h0, 12'h001), 32, 32'h0, 0);
      send_frame(0, mk(4'h0, 4'h0, 12'h010), 32, 32'h0, 0);
      send_frame(0, mk(4'h0, 4'h1, 12'h011), 32, 32'h0, 0);
      pulse_load();
      chk("R7 masked in", {20'h0, chv(0)}, 32'h010);
      chk("R7 masked out", {20'h0, chv(1)}, 32'h321);
      send_frame(0, mk(4'h6, 4'h0, 12'h0FF), 32, 32'h0, 0);
      pulse_load();
      chk("R7 unmasked", {20'h0, chv(1)}, 32'h011);

      // R8 clear codes
      send_frame(1, mk(4'h5, 4'h0, 12'h001), 32, 32'h0, 0);
      pulse_clear();
      chk("R8 mid ch5", {20'h0, chv(5)}, 32'h800);
      chk("R8 mid ch12", {20'h0, chv(12)}, 32'h800);
      pulse_load();
      chk("R8 input cleared", {20'h0, chv(9)}, 32'h800);
      send_frame(0, mk(4'h5, 4'h0, 12'h002), 32, 32'h0, 0);
      pulse_clear();
      chk("R8 full", {20'h0, chv(3)}, 32'hFFF);

      // R9 load ignored while clear low
      clear_n = 1'b0;
      wclk(8);
      send_frame(0, mk(4'h0, 4'h6, 12'h066), 32, 32'h0, 0);
      pulse_load();
      chk("R9 ignored", {20'h0, chv(6)}, 32'hFFF);
      clear_n = 1'b1;
      wclk(8);
      pulse_load();
      chk("R9 after release", {20'h0, chv(6)}, 32'h066);
      send_frame(0, mk(4'h5, 4'h0, 12'h003), 32, 32'h0, 0);
      pulse_clear();
      chk("R8 code3 zero", {20'h0, chv(6)}, 32'h0);

      // R10 power-down
      send_frame(1, mk(4'h4, 4'h0, 12'h281), 32, 32'h0, 0);
      chk("R10 ch8", {30'h0, pd_mode[16 +: 2]}, 32'h2);
      chk("R10 ch15", {30'h0, pd_mode[30 +: 2]}, 32'h2);
      chk("R10 ch9", {30'h0, pd_mode[18 +: 2]}, 32'h0);
      send_frame(0, mk(4'h4, 4'h0, 12'h304), 32, 32'h0, 0);
      chk("R10 ch2 tri", {30'h0, pd_mode[4 +: 2]}, 32'h3);
      send_frame(0, mk(4'h4, 4'h0, 12'h004), 32, 32'h0, 0);
      chk("R10 ch2 normal", {30'h0, pd_mode[4 +: 2]}, 32'h0);
      send_frame(1, mk(4'hA, 4'h0, 12'h3FF), 32, 32'h0, 0);
      chk("R12 pd untouched", {30'h0, pd_mode[18 +: 2]}, 32'h0);

      // R11 references
      send_frame(1, mk(4'h7, 4'h0, 12'h001), 32, 32'h0, 0);
      chk("R11 grp1 on", {30'h0, ref_on}, 32'h2);
      send_frame(0, mk(4'h7, 4'h0, 12'h001), 32, 32'h0, 0);
      chk("R11 both on", {30'h0, ref_on}, 32'h3);
      send_frame(1, mk(4'h7, 4'h0, 12'h000), 32, 32'h0, 0);
      chk("R11 grp1 off", {30'h0, ref_on}, 32'h1);

      done = 1'b1;
      report();
      $finish;
   end

endmodule